// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the current source and destination addresses for one DMA channel and moves each of them forward after the transfer that uses it. A completed read advances the source address. A completed write advances the destination address. Each side follows its own two-bit stepping mode:

- keep the address as it is,
- step up,
- step down,
- add a signed index register.

When the channel moves 32-bit double words, the up and down steps double in size, so each transfer covers both 16-bit words.

The channel sequencer loads the start addresses before a block transfer. It then pulses the done strobes as each read and write finishes. The address outputs come straight from registers, so they can feed the bus address path with no extra logic in front of them.

Top module: `dmaag_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both `src_addr` and `dst_addr` become 0 at that edge.
- R2: A high load input (`src_load` or `dst_load`) sets that side's address to the load value one edge later. This holds even when the matching done strobe is high in the same cycle.
- R3: The source address changes only on a load or on `rd_done`, and the destination address changes only on a load or on `wr_done`. A strobe for the other side has no effect.
- R4: With mode 2'b00, a done strobe leaves the address unchanged.
- R5: With mode 2'b01 and `dbl_mode` low, a done strobe adds 1 to the address.
- R6: With mode 2'b10 and `dbl_mode` low, a done strobe subtracts 1 from the address.
- R7: With mode 2'b11, a done strobe adds the side's signed 16-bit index to the address. This is the same whether `dbl_mode` is high or low.
- R8: With `dbl_mode` high, mode 2'b01 adds 2 and mode 2'b10 subtracts 2.
- R9: Address arithmetic wraps modulo 2^16. For example, 16'hFFFF + 1 gives 0, and 0 - 2 gives 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_load | input | 1 | Load the source start address |
| src_load_val | input | 16 | Source start address |
| dst_load | input | 1 | Load the destination start address |
| dst_load_val | input | 16 | Destination start address |
| rd_done | input | 1 | Read-complete strobe; advances the source address |
| wr_done | input | 1 | Write-complete strobe; advances the destination address |
| dbl_mode | input | 1 | Double-word transfers; doubles the up and down steps |
| src_mode | input | 2 | Source stepping mode (00 hold, 01 up, 10 down, 11 index) |
| dst_mode | input | 2 | Destination stepping mode (same encoding) |
| src_index | input | 16 | Signed source index |
| dst_index | input | 16 | Signed destination index |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
The hardest cases to reach are the wrap boundaries under each step size. Random start addresses almost never land next to 16'hFFFF or 0 just before a step of ±1 or ±2 in the right direction. Directed sequences therefore load addresses at both edges of the range and strobe them in every mode, with and without double-word mode. The same sequences also raise a load and a done strobe together, and pulse each side's strobe alone. Constrained random traffic with a fixed seed then mixes modes, negative indices and overlapping strobes, and checks every cycle against a bench model.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_IDX  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/dmaag_step.sv
module dmaag_step #(
  parameter int W = 16
) (
  input  logic [1:0]   mode,
  input  logic         dbl,
  input  logic [W-1:0] index,
  output logic [W-1:0] step
);
  import dmaag_pkg::*;
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] TWO     = W'(2);
  localparam logic [W-1:0] NEG_ONE = '1;
  localparam logic [W-1:0] NEG_TWO = '1 - ONE;

  always_comb begin
    unique case (step_mode_e'(mode))
      STEP_HOLD: step = '0;
      STEP_UP:   step = dbl ? TWO : ONE;
      STEP_DOWN: step = dbl ? NEG_TWO : NEG_ONE;
      default:   step = index;
    endcase
  end
endmodule

// File: rtl/dmaag_reg.sv
module dmaag_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [W-1:0] step,
  output logic [W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + step;
  end
endmodule

// File: rtl/dmaag_addr_gen.sv
module dmaag_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_load,
  input  logic [ADDR_W-1:0] src_load_val,
  input  logic              dst_load,
  input  logic [ADDR_W-1:0] dst_load_val,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic              dbl_mode,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic [ADDR_W-1:0] src_index,
  input  logic [ADDR_W-1:0] dst_index,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]             load_v, adv_v;
  logic [SIDES-1:0][1:0]        mode_v;
  logic [SIDES-1:0][ADDR_W-1:0] lval_v, idx_v, step_v, addr_v;

  assign load_v = {dst_load, src_load};
  assign adv_v  = {wr_done, rd_done};
  assign mode_v = {dst_mode, src_mode};
  assign lval_v = {dst_load_val, src_load_val};
  assign idx_v  = {dst_index, src_index};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dmaag_step #(.W(ADDR_W)) step_i (
      .mode  (mode_v[s]),
      .dbl   (dbl_mode),
      .index (idx_v[s]),
      .step  (step_v[s])
    );
    dmaag_reg #(.W(ADDR_W)) reg_i (
      .clk      (clk),
      .rst      (rst),
      .load     (load_v[s]),
      .load_val (lval_v[s]),
      .adv      (adv_v[s]),
      .step     (step_v[s]),
      .addr     (addr_v[s])
    );
  end

  assign src_addr = addr_v[0];
  assign dst_addr = addr_v[1];
endmodule

// File: rtl/dmaag_addr_gen_chk.sv
module dmaag_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              src_load,
  input logic [ADDR_W-1:0] src_load_val,
  input logic              dst_load,
  input logic [ADDR_W-1:0] dst_load_val,
  input logic              rd_done,
  input logic              wr_done,
  input logic              dbl_mode,
  input logic [1:0]        src_mode,
  input logic [1:0]        dst_mode,
  input logic [ADDR_W-1:0] src_index,
  input logic [ADDR_W-1:0] dst_index,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (src_addr == '0 && dst_addr == '0)); // R1

  AST_SRC_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    src_load |=> src_addr == $past(src_load_val)); // R2

  AST_DST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    dst_load |=> dst_addr == $past(dst_load_val)); // R2

  AST_SRC_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!src_load && !rd_done) |=> $stable(src_addr)); // R3

  AST_DST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && !wr_done) |=> $stable(dst_addr)); // R3

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!src_load && rd_done && src_mode == 2'b00) |=> $stable(src_addr)); // R4

  AST_SRC_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!src_load && rd_done && src_mode == 2'b01 && !dbl_mode)
      |=> src_addr == ADDR_W'($past(src_addr) + 1)); // R5

  AST_DST_DOWN_ONE: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && wr_done && dst_mode == 2'b10 && !dbl_mode)
      |=> dst_addr == ADDR_W'($past(dst_addr) - 1)); // R6

  AST_DST_INDEX: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && wr_done && dst_mode == 2'b11)
      |=> dst_addr == ADDR_W'($past(dst_addr) + $past(dst_index))); // R7

  AST_SRC_UP_TWO: assert property (@(posedge clk) disable iff (rst)
    (!src_load && rd_done && src_mode == 2'b01 && dbl_mode)
      |=> src_addr == ADDR_W'($past(src_addr) + 2)); // R8
endmodule

bind dmaag_addr_gen dmaag_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst),
  .src_load(src_load), .src_load_val(src_load_val),
  .dst_load(dst_load), .dst_load_val(dst_load_val),
  .rd_done(rd_done), .wr_done(wr_done), .dbl_mode(dbl_mode),
  .src_mode(src_mode), .dst_mode(dst_mode),
  .src_index(src_index), .dst_index(dst_index),
  .src_addr(src_addr), .dst_addr(dst_addr)
);

// File: tb/dmaag_addr_gen_tb_top.sv
module dmaag_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_load = 0, dst_load = 0, rd_done = 0, wr_done = 0, dbl_mode = 0;
  logic [15:0] src_load_val = 0, dst_load_val = 0, src_index = 0, dst_index = 0;
  logic [1:0]  src_mode = 0, dst_mode = 0;
  logic [15:0] src_addr, dst_addr;
  logic [15:0] exp_s = 0, exp_d = 0;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  dmaag_addr_gen dut_i (.*);

  function automatic logic [15:0] step_of(input logic [1:0] m, input logic dbl,
                                          input logic [15:0] idx);
    case (m)
      2'b00:   return 16'd0;
      2'b01:   return dbl ? 16'd2 : 16'd1;
      2'b10:   return dbl ? 16'hFFFE : 16'hFFFF;
      default: return idx;
    endcase
  endfunction

  function automatic string tag_of(input logic ld, input logic stb, input logic [1:0] m,
                                   input logic dbl);
    if (ld) return "R2";
    if (!stb) return "R3";
    case (m)
      2'b00:   return "R4";
      2'b01:   return dbl ? "R8" : "R5";
      2'b10:   return dbl ? "R8" : "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Applies the current inputs for one edge, updates the model, checks at the next falling edge.
  task automatic cycle(input string extra = "");
    string ts, td;
    ts = tag_of(src_load, rd_done, src_mode, dbl_mode);
    td = tag_of(dst_load, wr_done, dst_mode, dbl_mode);
    if (src_load) exp_s = src_load_val;
    else if (rd_done) exp_s = exp_s + step_of(src_mode, dbl_mode, src_index);
    if (dst_load) exp_d = dst_load_val;
    else if (wr_done) exp_d = exp_d + step_of(dst_mode, dbl_mode, dst_index);
    @(negedge clk);
    check({ts, extra, " src"}, src_addr, exp_s);
    check({td, extra, " dst"}, dst_addr, exp_d);
  endtask

  task automatic idle();
    src_load = 0; dst_load = 0; rd_done = 0; wr_done = 0;
  endtask

  task automatic load_both(input logic [15:0] s, input logic [15:0] d);
    idle(); src_load = 1; dst_load = 1; src_load_val = s; dst_load_val = d;
    cycle(); idle();
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1 src", src_addr, 16'h0);
    check("R1 dst", dst_addr, 16'h0);
    rst = 0;

    // R9: wrap upward by 1 and 2
    load_both(16'hFFFF, 16'hFFFE);
    src_mode = 2'b01; dst_mode = 2'b01; dbl_mode = 0; rd_done = 1; wr_done = 1;
    cycle(" R9");
    idle(); load_both(16'hFFFF, 16'hFFFE);
    dbl_mode = 1; rd_done = 1; wr_done = 1; cycle(" R9");
    // R9: wrap downward
    idle(); load_both(16'h0000, 16'h0001);
    src_mode = 2'b10; dst_mode = 2'b10; dbl_mode = 1; rd_done = 1; wr_done = 1;
    cycle(" R9");
    dbl_mode = 0; cycle(" R9");
    // R7: negative index, unchanged by double-word mode
    idle(); load_both(16'h0010, 16'h8000);
    src_mode = 2'b11; dst_mode = 2'b11; src_index = 16'hFFF0; dst_index = 16'h0123;
    dbl_mode = 1; rd_done = 1; wr_done = 1; cycle();
    // R2: load beats strobe
    src_load = 1; src_load_val = 16'hABCD; dst_load = 1; dst_load_val = 16'h1357;
    cycle();
    // R3: one side's strobe leaves the other alone
    idle(); src_mode = 2'b01; dst_mode = 2'b01; wr_done = 1; cycle();
    idle(); rd_done = 1; cycle();
    // R4: hold mode
    idle(); src_mode = 2'b00; dst_mode = 2'b00; rd_done = 1; wr_done = 1; cycle();
    idle();

    for (int i = 0; i < 3000; i++) begin
      src_load = ($urandom_range(0, 15) == 0);
      dst_load = ($urandom_range(0, 15) == 0);
      src_load_val = (i % 50 < 3) ? 16'hFFFF : 16'($urandom);
      dst_load_val = (i % 50 < 3) ? 16'h0000 : 16'($urandom);
      rd_done = $urandom_range(0, 1) == 1;
      wr_done = $urandom_range(0, 1) == 1;
      dbl_mode = $urandom_range(0, 1) == 1;
      src_mode = 2'($urandom); dst_mode = 2'($urandom);
      src_index = 16'($urandom); dst_index = 16'($urandom);
      cycle();
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule